// File: doc/BRIEF.md
# DMA Peripheral Request-Side Controller

This block sits on the peripheral end of a DMA request/acknowledge link. Local FIFO-level logic asks it for a single transfer or a burst, and says whether that request carries the final data of the transfer. The block turns each local request into a typed request on the outbound request channel. It holds that request steady until the DMA controller takes it.

The inbound acknowledge channel carries two kinds of message from the controller: transfer-complete notices and flush requests. The block raises its ready line to complete each handshake. It reports a completed single or burst transfer to local logic as a one-cycle pulse. Each flush request is answered automatically with a flush-acknowledge request on the outbound channel, and that answer takes priority over local requests. A channel-active input marks whether the controller's channel is running. While it is low, the handshake rules are suspended and the block drops back to idle.

Top module: `dma_req_agent`

## Requirements
- R1: Synchronous reset drives rq_valid, ak_ready, loc_ready, rq_last, all event pulses and rsvd_err low, and rq_type to 2'b00.
- R2: A local request launches with rq_type 2'b00 when loc_burst is 0 and 2'b01 when loc_burst is 1. A flush acknowledge launches with 2'b10. The code 2'b11 is never driven while rq_valid is high.
- R3: Once rq_valid is high, it stays high with rq_type and rq_last unchanged until a cycle in which rq_ready is high (channel active). rq_valid falls in the cycle after that handshake.
- R4: rq_last carries loc_last for single and burst requests and is low for a flush acknowledge.
- R5: An acknowledge handshake (ak_valid and ak_ready high) with ak_type 2'b00 gives a one-cycle evt_single pulse in the next cycle. With 2'b01 it gives evt_burst, and with 2'b10 it gives evt_flush.
- R6: ak_ready rises in the cycle after ak_valid is seen high while ak_ready is low, and it is high for exactly one cycle per handshake.
- R7: At most one request is outstanding. loc_ready is high only when the channel was active in the previous cycle, no request is in flight and no flush is pending. A request is accepted on loc_valid and loc_ready and launches in the next cycle.
- R8: A received flush request sets a pending flag. Once the request channel is idle, the pending flush launches as a type 2'b10 request before any local request.
- R9: An acknowledge handshake with the reserved type 2'b11 completes normally but sets rsvd_err, which stays high until reset. It produces no event pulse and no flush.
- R10: While chan_active is low, rq_valid and ak_ready go low in the next cycle, a pending flush is discarded and no request launches. A local request accepted in such a cycle is dropped.
- R11: A flush request that arrives in the same cycle as the launch of an earlier pending flush leaves a new pending flush, so every flush request gets its own acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_active | input | 1 | Controller channel is running (not stopped) |
| loc_valid | input | 1 | Local request offered |
| loc_burst | input | 1 | Local request kind: 0 single, 1 burst |
| loc_last | input | 1 | Local request covers the final data |
| loc_ready | output | 1 | Block can take a local request |
| rq_valid | output | 1 | Request channel valid |
| rq_type | output | KIND_W | Request kind: 00 single, 01 burst, 10 flush acknowledge |
| rq_last | output | 1 | Request covers the final data |
| rq_ready | input | 1 | Controller accepts the request |
| ak_valid | input | 1 | Acknowledge channel valid |
| ak_type | input | KIND_W | 00 single done, 01 burst done, 10 flush request, 11 reserved |
| ak_ready | output | 1 | Block accepts the acknowledge message |
| evt_single | output | 1 | Single transfer completed (pulse) |
| evt_burst | output | 1 | Burst transfer completed (pulse) |
| evt_flush | output | 1 | Flush request received (pulse) |
| rsvd_err | output | 1 | Sticky: reserved acknowledge type seen |

## Verification
Two functions can collide in one cycle. A flush request can complete on the acknowledge channel in the same cycle that an earlier pending flush launches, or that a local request is accepted. The collision is provoked by holding ak_valid with a flush type back-to-back while rq_ready is held high and local requests are offered, and random traffic adds more such cases. It is judged two ways: the order and contents of every outbound request are compared each cycle against a bench model, and the bench confirms that the number of flush acknowledges issued equals the number of flush requests taken.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
   localparam int unsigned CODE_W = 2;

   // request channel codes
   localparam logic [CODE_W-1:0] RQ_SINGLE    = 2'b00;
   localparam logic [CODE_W-1:0] RQ_BURST     = 2'b01;
   localparam logic [CODE_W-1:0] RQ_FLUSH_ACK = 2'b10;

   // acknowledge channel codes
   localparam logic [CODE_W-1:0] AK_SINGLE_DONE = 2'b00;
   localparam logic [CODE_W-1:0] AK_BURST_DONE  = 2'b01;
   localparam logic [CODE_W-1:0] AK_FLUSH_REQ   = 2'b10;
   localparam logic [CODE_W-1:0] AK_RESERVED    = 2'b11;

   typedef struct packed {
      logic single_done;
      logic burst_done;
      logic flush_req;
   } ak_evt_t;
endpackage

// File: rtl/dma_req_ack_rx.sv
module dma_req_ack_rx
   import dma_req_pkg::*;
#(
   parameter int unsigned KIND_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              active,
   input  logic              ak_valid,
   input  logic [KIND_W-1:0] ak_type,
   output logic              ak_ready,
   output ak_evt_t           evt,
   output logic              err,
   output logic              flush_hs
);
   logic    rdy_q;
   logic    err_q;
   ak_evt_t evt_q;
   logic    fire;

   assign fire     = active & ak_valid & rdy_q;
   assign flush_hs = fire & (ak_type == AK_FLUSH_REQ);

   always_ff @(posedge clk) begin
      if (rst) begin
         rdy_q <= 1'b0;
         err_q <= 1'b0;
         evt_q <= '0;
      end else begin
         rdy_q             <= active & ak_valid & ~rdy_q;
         evt_q.single_done <= fire & (ak_type == AK_SINGLE_DONE);
         evt_q.burst_done  <= fire & (ak_type == AK_BURST_DONE);
         evt_q.flush_req   <= fire & (ak_type == AK_FLUSH_REQ);
         if (fire && (ak_type == AK_RESERVED)) begin
            err_q <= 1'b1;
         end
      end
   end

   assign ak_ready = rdy_q;
   assign evt      = evt_q;
   assign err      = err_q;
endmodule

// File: rtl/dma_req_issue.sv
module dma_req_issue
   import dma_req_pkg::*;
#(
   parameter int unsigned KIND_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              active,
   input  logic              flush_hs,
   input  logic              loc_valid,
   input  logic              loc_burst,
   input  logic              loc_last,
   output logic              loc_ready,
   output logic              rq_valid,
   output logic [KIND_W-1:0] rq_type,
   output logic              rq_last,
   input  logic              rq_ready
);
   logic              vld_q;
   logic              last_q;
   logic              pend_q;
   logic              act_q;
   logic [KIND_W-1:0] kind_q;
   logic              take_flush;
   logic              take_loc;
   logic              slot_free;

   assign slot_free  = act_q & ~vld_q & ~pend_q;
   assign take_flush = ~vld_q & pend_q;
   assign take_loc   = loc_valid & slot_free;

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q  <= 1'b0;
         last_q <= 1'b0;
         pend_q <= 1'b0;
         act_q  <= 1'b0;
         kind_q <= RQ_SINGLE;
      end else begin
         act_q <= active;
         if (!active) begin
            vld_q  <= 1'b0;
            pend_q <= 1'b0;
         end else begin
            pend_q <= flush_hs | (pend_q & ~take_flush);
            if (vld_q && rq_ready) begin
               vld_q <= 1'b0;
            end else if (take_flush) begin
               vld_q  <= 1'b1;
               kind_q <= RQ_FLUSH_ACK;
               last_q <= 1'b0;
            end else if (take_loc) begin
               vld_q  <= 1'b1;
               kind_q <= loc_burst ? RQ_BURST : RQ_SINGLE;
               last_q <= loc_last;
            end
         end
      end
   end

   assign loc_ready = slot_free;
   assign rq_valid  = vld_q;
   assign rq_type   = kind_q;
   assign rq_last   = last_q;
endmodule

// File: rtl/dma_req_agent.sv
module dma_req_agent
   import dma_req_pkg::*;
#(
   parameter int unsigned KIND_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              chan_active,
   input  logic              loc_valid,
   input  logic              loc_burst,
   input  logic              loc_last,
   output logic              loc_ready,
   output logic              rq_valid,
   output logic [KIND_W-1:0] rq_type,
   output logic              rq_last,
   input  logic              rq_ready,
   input  logic              ak_valid,
   input  logic [KIND_W-1:0] ak_type,
   output logic              ak_ready,
   output logic              evt_single,
   output logic              evt_burst,
   output logic              evt_flush,
   output logic              rsvd_err
);
   generate
      if (KIND_W != CODE_W) begin : g_bad_width
         $error("dma_req_agent: KIND_W must equal the two-bit code width");
      end
   endgenerate

   ak_evt_t evt;
   logic    flush_hs;

   dma_req_ack_rx #(.KIND_W(KIND_W)) u_ack_rx (
      .clk      (clk),
      .rst      (rst),
      .active   (chan_active),
      .ak_valid (ak_valid),
      .ak_type  (ak_type),
      .ak_ready (ak_ready),
      .evt      (evt),
      .err      (rsvd_err),
      .flush_hs (flush_hs)
   );

   dma_req_issue #(.KIND_W(KIND_W)) u_issue (
      .clk       (clk),
      .rst       (rst),
      .active    (chan_active),
      .flush_hs  (flush_hs),
      .loc_valid (loc_valid),
      .loc_burst (loc_burst),
      .loc_last  (loc_last),
      .loc_ready (loc_ready),
      .rq_valid  (rq_valid),
      .rq_type   (rq_type),
      .rq_last   (rq_last),
      .rq_ready  (rq_ready)
   );

   assign evt_single = evt.single_done;
   assign evt_burst  = evt.burst_done;
   assign evt_flush  = evt.flush_req;
endmodule

// File: rtl/dma_req_agent_chk.sv
module dma_req_agent_chk #(
   parameter int unsigned KIND_W = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              chan_active,
   input logic              loc_valid,
   input logic              loc_burst,
   input logic              loc_last,
   input logic              loc_ready,
   input logic              rq_valid,
   input logic [KIND_W-1:0] rq_type,
   input logic              rq_last,
   input logic              rq_ready,
   input logic              ak_valid,
   input logic [KIND_W-1:0] ak_type,
   input logic              ak_ready,
   input logic              evt_single,
   input logic              evt_burst,
   input logic              evt_flush,
   input logic              rsvd_err
);
   p_no_rsvd_r2: assert property (@(posedge clk) disable iff (rst)
      rq_valid |-> (rq_type != 2'b11));

   p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (rq_valid && !rq_ready && chan_active) |=>
         (rq_valid && $stable(rq_type) && $stable(rq_last)));

   p_flush_last_r4: assert property (@(posedge clk) disable iff (rst)
      (rq_valid && rq_type == 2'b10) |-> !rq_last);

   p_evt_single_r5: assert property (@(posedge clk) disable iff (rst)
      evt_single |-> $past(ak_valid && ak_ready && ak_type == 2'b00));

   p_evt_flush_r5: assert property (@(posedge clk) disable iff (rst)
      evt_flush |-> $past(ak_valid && ak_ready && ak_type == 2'b10));

   p_ack_rdy_r6: assert property (@(posedge clk) disable iff (rst)
      ak_ready |-> $past(ak_valid && !ak_ready));

   p_one_out_r7: assert property (@(posedge clk) disable iff (rst)
      (loc_valid && loc_ready) |-> !rq_valid);

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      rsvd_err |=> rsvd_err);

   p_rsvd_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      (ak_valid && ak_ready && ak_type == 2'b11) |=>
         (!evt_single && !evt_burst && !evt_flush));

   p_stop_r10: assert property (@(posedge clk) disable iff (rst)
      !chan_active |=> (!rq_valid && !ak_ready));
endmodule

bind dma_req_agent dma_req_agent_chk #(.KIND_W(KIND_W)) u_chk (.*);

// File: tb/dma_req_agent_bench.sv
module dma_req_agent_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       chan_active = 1'b0;
   logic       loc_valid = 1'b0, loc_burst = 1'b0, loc_last = 1'b0;
   logic       rq_ready = 1'b0;
   logic       ak_valid = 1'b0;
   logic [1:0] ak_type = 2'b00;
   logic       loc_ready, rq_valid, rq_last, ak_ready;
   logic [1:0] rq_type;
   logic       evt_single, evt_burst, evt_flush, rsvd_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model state
   logic       m_vld = 0, m_last = 0, m_pend = 0, m_act = 0, m_akr = 0;
   logic [1:0] m_kind = 0;
   logic       m_es = 0, m_eb = 0, m_ef = 0, m_err = 0, m_locr = 0;
   logic       last_loc_fire = 0, last_ak_fire = 0;
   int         n_ak_flush = 0, n_rq_flush = 0;

   always #2 clk = ~clk;

   dma_req_agent u_dma_req_agent (.*);

   task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0d exp %0d", tag, got, exp);
      end
   endtask

   task automatic model_next();
      logic fire_ak, nflush, tf;
      if (rst) begin
         {m_vld, m_last, m_pend, m_act, m_akr, m_kind} = '0;
         {m_es, m_eb, m_ef, m_err, m_locr} = '0;
      end else begin
         fire_ak = chan_active & ak_valid & m_akr;
         nflush  = fire_ak & (ak_type == 2'b10);
         m_akr   = chan_active & ak_valid & ~m_akr;
         m_es    = fire_ak & (ak_type == 2'b00);
         m_eb    = fire_ak & (ak_type == 2'b01);
         m_ef    = nflush;
         m_err   = m_err | (fire_ak & (ak_type == 2'b11));
         if (!chan_active) begin
            m_vld  = 0;
            m_pend = 0;
         end else begin
            tf = ~m_vld & m_pend;
            if (m_vld && rq_ready) m_vld = 0;
            else if (tf) begin m_vld = 1; m_kind = 2'b10; m_last = 0; end
            else if (loc_valid && m_locr) begin
               m_vld = 1; m_kind = {1'b0, loc_burst}; m_last = loc_last;
            end
            m_pend = nflush | (m_pend & ~tf);
         end
         m_act  = chan_active;
         m_locr = m_act & ~m_vld & ~m_pend;
      end
   endtask

   // one clock: inputs already driven just after a negedge
   task automatic step();
      #1;
      last_loc_fire = loc_valid & loc_ready;
      last_ak_fire  = ak_valid & ak_ready & chan_active;
      if (last_ak_fire && ak_type == 2'b10) n_ak_flush++;
      if (rq_valid && rq_ready && chan_active && rq_type == 2'b10) n_rq_flush++;
      model_next();
      @(negedge clk);
      chk("R3 rq_valid", {1'b0, rq_valid}, {1'b0, m_vld});
      chk("R2 rq_type", rq_type, m_kind);
      chk("R4 rq_last", {1'b0, rq_last}, {1'b0, m_last});
      chk("R7 loc_ready", {1'b0, loc_ready}, {1'b0, m_locr});
      chk("R6 ak_ready", {1'b0, ak_ready}, {1'b0, m_akr});
      chk("R5 evt_single", {1'b0, evt_single}, {1'b0, m_es});
      chk("R5 evt_burst", {1'b0, evt_burst}, {1'b0, m_eb});
      chk("R8 evt_flush", {1'b0, evt_flush}, {1'b0, m_ef});
      chk("R9 rsvd_err", {1'b0, rsvd_err}, {1'b0, m_err});
   endtask

   task automatic finish_ak();
      for (int i = 0; i < 10 && ak_valid; i++) begin
         if (ak_ready) begin step(); ak_valid = 0; end
         else step();
      end
   endtask

   initial begin : watchdog
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [1:0] seen;
      void'($urandom(32'h5eed_1234));
      // R1: reset state
      for (int i = 0; i < 3; i++) step();
      chk("R1 reset rq_valid", {1'b0, rq_valid}, 2'd0);
      chk("R1 reset rq_type", rq_type, 2'd0);
      chk("R1 reset ak_ready", {1'b0, ak_ready}, 2'd0);
      chk("R1 reset loc_ready", {1'b0, loc_ready}, 2'd0);
      rst = 0; chan_active = 1;
      step(); step();

      // single request with last, held while not ready (R2 R3 R4)
      loc_valid = 1; loc_burst = 0; loc_last = 1;
      for (int i = 0; i < 4 && !last_loc_fire; i++) step();
      loc_burst = 1; loc_last = 0;           // next local offer: burst
      for (int i = 0; i < 4; i++) step();    // rq_ready low: must hold
      chk("R3 held single", {rq_valid, rq_last}, 2'b11);

      // flush request while request in flight (R8)
      ak_valid = 1; ak_type = 2'b10;
      finish_ak();
      rq_ready = 1;
      step();                                 // handshake completes
      rq_ready = 0;
      for (int i = 0; i < 6 && !rq_valid; i++) step();
      chk("R8 flush first", rq_type, 2'b10);
      chk("R4 flush last low", {1'b0, rq_last}, 2'd0);
      rq_ready = 1; step(); rq_ready = 0;
      for (int i = 0; i < 6 && !rq_valid; i++) step();
      chk("R2 burst after flush", rq_type, 2'b01);
      rq_ready = 1; step(); loc_valid = 0; step(); rq_ready = 0;

      // completions (R5) and reserved type (R9)
      ak_valid = 1; ak_type = 2'b00; finish_ak(); step();
      ak_valid = 1; ak_type = 2'b01; finish_ak(); step();
      ak_valid = 1; ak_type = 2'b11; finish_ak();
      step(); step();
      chk("R9 sticky err", {1'b0, rsvd_err}, 2'd1);
      chk("R9 no flush", {1'b0, rq_valid}, 2'd0);

      // stop with request outstanding and flush pending (R10)
      loc_valid = 1; loc_burst = 0; loc_last = 0;
      for (int i = 0; i < 4 && !last_loc_fire; i++) step();
      loc_valid = 0;
      ak_valid = 1; ak_type = 2'b10; finish_ak();
      chan_active = 0; step();
      chk("R10 stopped valid", {1'b0, rq_valid}, 2'd0);
      step(); step();
      chan_active = 1; step(); step(); step();
      chk("R10 flush discarded", {1'b0, rq_valid}, 2'd0);

      // back-to-back flush requests colliding with launches (R11)
      n_ak_flush = 0; n_rq_flush = 0;
      rq_ready = 1; loc_valid = 1; loc_burst = 1; loc_last = 1;
      ak_valid = 1; ak_type = 2'b10;
      for (int i = 0; i < 24; i++) begin
         step();
         if (last_loc_fire) loc_last = ~loc_last;
      end
      finish_ak(); loc_valid = 0;
      for (int i = 0; i < 12; i++) step();
      chk("R11 flush count", n_rq_flush[1:0], n_ak_flush[1:0]);
      checks++;
      if (n_rq_flush != n_ak_flush || n_ak_flush < 3) begin
         errors++;
         $display("FAIL R11 flush acks got %0d exp %0d", n_rq_flush, n_ak_flush);
      end

      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         if (!loc_valid || last_loc_fire) begin
            loc_valid = ($urandom % 3) != 0;
            loc_burst = $urandom % 2;
            loc_last  = $urandom % 2;
         end
         if (!ak_valid || last_ak_fire) begin
            ak_valid = ($urandom % 4) == 0;
            ak_type  = (($urandom % 16) == 0) ? 2'b11 : 2'($urandom % 3);
         end
         rq_ready    = $urandom % 2;
         chan_active = ($urandom % 300) != 0;
         step();
      end
      seen = {1'b0, rsvd_err};
      chk("R9 err kept", seen, 2'd1);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule